// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits behind the serial front-end of a small byte-addressed non-volatile store. When the front-end has decoded a memory-write command and its address, it pulses a start strobe. The block latches the page part of the address and the starting slot inside the page. Each data byte that follows goes into a page buffer of `PAGE_BYTES` slots. The slot pointer moves forward by one after every byte and wraps inside the page, so a long burst overwrites the bytes it sent earlier.

When chip select rises, the front-end reports the event together with two conditions: whether a partial byte is pending, and whether the protection logic permits the write. The block starts a program cycle only if chip select rose on a byte boundary, at least one byte was received, and the write is permitted. In any other case the buffer is dropped and the block goes back to idle. A program cycle lasts exactly `PROG_CYCLES` clock cycles, during which busy is high. In the first `PAGE_BYTES` of those cycles the block walks the slots in ascending order and strobes only the slots that received a byte. The last busy cycle carries a one-cycle request to clear the write-enable latch. `PROG_CYCLES` must be at least `PAGE_BYTES`.

Top module: `page_program_seq`

## Requirements
- R1: During and right after reset, `busy`, `arr_we` and `wel_clear` are 0.
- R2: The first data byte after `txn_start` goes to slot `txn_addr` mod `PAGE_BYTES`. Each further byte goes to the next slot. The array address of a slot is the page bits of `txn_addr` (bits ADDR_W-1 down to log2(PAGE_BYTES)) joined with the slot number in the low bits.
- R3: If more than `PAGE_BYTES` bytes arrive, the slot pointer wraps to 0. Each slot is programmed once, with the last byte it received.
- R4: A program cycle starts only when `cs_rise` arrives during a write transaction with `bits_pending`=0, `permit`=1 and at least one byte received. `bits_pending`=1 at `cs_rise` starts nothing and discards the buffer.
- R5: `permit`=0 at `cs_rise` starts nothing and programs nothing. The buffered bytes are discarded and never reach the array later.
- R6: `busy` goes high in the cycle after the committing `cs_rise` and stays high for exactly `PROG_CYCLES` cycles.
- R7: `wel_clear` is a single-cycle pulse in the last busy cycle of each program cycle and is 0 at all other times.
- R8: `arr_we` is high only while busy. In busy cycle k (k counted from 0, k < `PAGE_BYTES`) it strobes slot k, and only if that slot received a byte. Slots that received no byte are not written.
- R9: While busy, `txn_start`, `byte_valid` and `cs_rise` are ignored. A transaction sent during a program cycle causes no second program cycle and no array write.
- R10: A `txn_start` during an open transaction discards the bytes received so far and restarts collection at the new address.
- R11: A `cs_rise` with no write transaction open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Pulse: a write command with its address has been decoded |
| txn_addr | input | ADDR_W | Start address of the write, valid with `txn_start` |
| byte_valid | input | 1 | Pulse: one complete data byte received |
| byte_data | input | DATA_W | Data byte, valid with `byte_valid` |
| cs_rise | input | 1 | Pulse: chip select went inactive |
| bits_pending | input | 1 | With `cs_rise`: a partial byte had been shifted in |
| permit | input | 1 | With `cs_rise`: protection logic allows this write |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| wel_clear | output | 1 | Pulse: clear the write-enable latch |

## Verification
The assertions assume that the front-end raises `txn_start`, `byte_valid` and `cs_rise` as single-cycle pulses from the system clock domain, with `bits_pending` and `permit` valid in the cycle of `cs_rise`. They also assume that chip select does not rise in the same cycle as a start strobe. The bench drives every input at the falling clock edge as a pulse of one cycle. It never overlaps `cs_rise` with a start or a byte strobe. Its random pick of burst length, gaps, pending bits and permission keeps within those rules, and a few directed sequences deliberately send traffic while busy.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PROG = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic start;
        logic data;
        logic close;
        logic clean;
        logic allowed;
    } txn_evt_t;

    function automatic logic commit_ok(txn_evt_t e, logic have_bytes);
        return e.close && e.clean && e.allowed && have_bytes;
    endfunction

endpackage

// File: rtl/pwb_page_buffer.sv
module pwb_page_buffer #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [OFF_W-1:0]  start_off,
    input  logic              store,
    input  logic [DATA_W-1:0] store_data,
    input  logic [OFF_W-1:0]  rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    logic [OFF_W-1:0]      off_q;
    logic [PAGE_BYTES-1:0] valid_w;
    logic [DATA_W-1:0]     data_w [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst)        off_q <= '0;
        else if (load)  off_q <= start_off;
        else if (store) off_q <= off_q + 1'b1;
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic              v_q;
        logic [DATA_W-1:0] d_q;
        logic              hit;

        assign hit = store && (off_q == OFF_W'(g));

        always_ff @(posedge clk) begin
            if (rst)                v_q <= 1'b0;
            else if (clear || load) v_q <= 1'b0;
            else if (hit)           v_q <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (hit) d_q <= store_data;
        end

        assign valid_w[g] = v_q;
        assign data_w[g]  = d_q;
    end

    assign rd_data   = data_w[rd_slot];
    assign rd_valid  = valid_w[rd_slot];
    assign any_valid = |valid_w;

endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
    parameter int PROG_CYCLES = 64,
    parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             active,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROG_CYCLES - 1);

    assign last = active && (count == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            count  <= '0;
        end else if (start) begin
            active <= 1'b1;
            count  <= '0;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
                count  <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/page_program_seq.sv
module page_program_seq
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 8,
    parameter int PROG_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              bits_pending,
    input  logic              permit,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              wel_clear
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int CNT_W  = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] PAGE_LIM = CNT_W'(PAGE_BYTES);

    seq_state_t        state_q, state_d;
    txn_evt_t          evt;
    logic [PAGE_W-1:0] page_q;
    logic              any_byte, go, abort, load, store;
    logic              tmr_active, tmr_last;
    logic [CNT_W-1:0]  tmr_cnt;
    logic [DATA_W-1:0] slot_data;
    logic              slot_valid;

    assign evt = '{start: txn_start, data: byte_valid, close: cs_rise,
                   clean: !bits_pending, allowed: permit};

    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        abort   = 1'b0;
        load    = 1'b0;
        store   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (evt.start) begin
                    load    = 1'b1;
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (evt.close) begin
                    if (commit_ok(evt, any_byte)) begin
                        go      = 1'b1;
                        state_d = ST_PROG;
                    end else begin
                        abort   = 1'b1;
                        state_d = ST_IDLE;
                    end
                end else if (evt.start) begin
                    load = 1'b1;
                end else if (evt.data) begin
                    store = 1'b1;
                end
            end
            ST_PROG: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)       page_q <= '0;
        else if (load) page_q <= txn_addr[ADDR_W-1:OFF_W];
    end

    pwb_page_buffer #(
        .DATA_W    (DATA_W),
        .PAGE_BYTES(PAGE_BYTES),
        .OFF_W     (OFF_W)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clear     (abort | tmr_last),
        .load      (load),
        .start_off (txn_addr[OFF_W-1:0]),
        .store     (store),
        .store_data(byte_data),
        .rd_slot   (tmr_cnt[OFF_W-1:0]),
        .rd_data   (slot_data),
        .rd_valid  (slot_valid),
        .any_valid (any_byte)
    );

    pwb_prog_timer #(
        .PROG_CYCLES(PROG_CYCLES),
        .CNT_W      (CNT_W)
    ) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (go),
        .active(tmr_active),
        .count (tmr_cnt),
        .last  (tmr_last)
    );

    assign busy      = tmr_active;
    assign arr_we    = tmr_active && (tmr_cnt < PAGE_LIM) && slot_valid;
    assign arr_addr  = {page_q, tmr_cnt[OFF_W-1:0]};
    assign arr_data  = slot_data;
    assign wel_clear = tmr_last;

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int PROG_CYCLES = 64
) (
    input logic clk,
    input logic rst,
    input logic cs_rise,
    input logic bits_pending,
    input logic permit,
    input logic busy,
    input logic arr_we,
    input logic wel_clear
);

    localparam int BL_W = $clog2(PROG_CYCLES + 1) + 1;
    localparam logic [BL_W-1:0] FULL_LEN = BL_W'(PROG_CYCLES);

    logic [BL_W-1:0] blen;

    always_ff @(posedge clk) begin
        if (rst)       blen <= '0;
        else if (busy) blen <= blen + 1'b1;
        else           blen <= '0;
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (!busy && !arr_we && !wel_clear));

    a_r8_write_in_busy: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    a_r7_wel_in_busy: assert property (@(posedge clk) disable iff (rst)
        wel_clear |-> busy);

    a_r7_wel_ends_busy: assert property (@(posedge clk) disable iff (rst)
        wel_clear |=> !busy);

    a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
        (!busy && blen != '0) |-> (blen == FULL_LEN));

    a_r6_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (blen < FULL_LEN));

    a_r4_commit_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_rise && !bits_pending && permit));

endmodule

bind page_program_seq pwb_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_rise     (cs_rise),
    .bits_pending(bits_pending),
    .permit      (permit),
    .busy        (busy),
    .arr_we      (arr_we),
    .wel_clear   (wel_clear)
);

// File: tb/page_program_seq_test.sv
module page_program_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int PB   = 8;
    localparam int PROG = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txn_start = 0, byte_valid = 0, cs_rise = 0, bits_pending = 0, permit = 0;
    logic [AW-1:0] txn_addr = '0;
    logic [DW-1:0] byte_data = '0;
    logic busy, arr_we, wel_clear;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_program_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_addr(txn_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
        .bits_pending(bits_pending), .permit(permit), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data), .wel_clear(wel_clear)
    );

    int checks = 0;
    int errors = 0;

    // bench view of the storage array, and its expected image
    logic [DW-1:0] got_mem [2**AW];
    logic [DW-1:0] exp_mem [2**AW];

    // observation counters, cleared per scenario
    int busy_cycles, busy_rises, wel_cnt, wr_cnt, order_bad, bidx;
    logic prev_busy = 1'b0;

    // transaction model
    logic [DW-1:0] ebuf [PB];
    logic [PB-1:0] evalid;
    int  eoff;
    logic [AW-1:0] ebase;
    logic open_txn;

    function automatic logic [AW-1:0] slot_addr(logic [AW-1:0] base, int k);
        return {base[AW-1:3], 3'(k)};
    endfunction

    function automatic int count_valid(logic [PB-1:0] v);
        int n = 0;
        for (int i = 0; i < PB; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) begin
                busy_cycles++;
                if (!prev_busy) begin
                    busy_rises++;
                    bidx = 0;
                end else begin
                    bidx++;
                end
            end
            if (arr_we) begin
                wr_cnt++;
                got_mem[arr_addr] = arr_data;
                if (!busy || int'(arr_addr[2:0]) != bidx || bidx >= PB) order_bad++;
            end
            if (wel_clear) begin
                wel_cnt++;
                if (!busy || bidx != PROG - 1) order_bad++;
            end
            prev_busy = busy;
        end
    end

    task automatic clear_obs();
        busy_cycles = 0; busy_rises = 0; wel_cnt = 0; wr_cnt = 0; order_bad = 0;
    endtask

    task automatic drive_start(input logic [AW-1:0] a);
        @(negedge clk); txn_start = 1; txn_addr = a;
        @(negedge clk); txn_start = 0;
    endtask

    task automatic drive_byte(input logic [DW-1:0] d);
        @(negedge clk); byte_valid = 1; byte_data = d;
        @(negedge clk); byte_valid = 0;
    endtask

    task automatic drive_close(input logic pend, input logic perm);
        @(negedge clk); cs_rise = 1; bits_pending = pend; permit = perm;
        @(negedge clk); cs_rise = 0; bits_pending = 0; permit = 0;
    endtask

    task automatic m_start(input logic [AW-1:0] a);
        drive_start(a);
        ebase = a; eoff = int'(a[2:0]); evalid = '0; open_txn = 1;
    endtask

    task automatic m_byte(input logic [DW-1:0] d);
        drive_byte(d);
        ebuf[eoff] = d; evalid[eoff] = 1'b1; eoff = (eoff + 1) % PB;
    endtask

    task automatic m_close(input logic pend, input logic perm, output logic commit, output int expw);
        drive_close(pend, perm);
        commit = open_txn && (evalid != '0) && !pend && perm;
        expw = 0;
        if (commit) begin
            expw = count_valid(evalid);
            for (int k = 0; k < PB; k++)
                if (evalid[k]) exp_mem[slot_addr(ebase, k)] = ebuf[k];
        end
        open_txn = 0;
    endtask

    task automatic settle();
        repeat (PROG + 5) @(negedge clk);
    endtask

    task automatic check_outcome(input logic commit, input int expw, input string rq);
        int mism = 0;
        check(busy_cycles == (commit ? PROG : 0), "R6 busy length", busy_cycles, commit ? PROG : 0);
        check(wel_cnt == int'(commit), "R7 wel_clear pulses", wel_cnt, int'(commit));
        check(wr_cnt == expw && order_bad == 0, "R8 write count/order", wr_cnt * 100 + order_bad, expw * 100);
        for (int i = 0; i < 2**AW; i++) if (got_mem[i] !== exp_mem[i]) mism++;
        check(mism == 0, rq, mism, 0);
    endtask

    initial begin
        logic commit;
        int expw, n;
        logic [AW-1:0] a;
        void'($urandom(32'd2024));
        for (int i = 0; i < 2**AW; i++) begin got_mem[i] = '0; exp_mem[i] = '0; end
        open_txn = 0; evalid = '0; eoff = 0; ebase = '0;
        clear_obs();

        repeat (3) @(negedge clk);
        check(busy == 0 && arr_we == 0 && wel_clear == 0, "R1 outputs in reset", int'(busy), 0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        check(busy == 0, "R1 busy after reset", int'(busy), 0);
        check(arr_we == 0 && wel_clear == 0, "R1 strobes after reset", int'(arr_we), 0);

        // R2: three bytes from mid-page
        clear_obs(); m_start(8'h45);
        m_byte(8'hA1); m_byte(8'hA2); m_byte(8'hA3);
        m_close(0, 1, commit, expw); settle();
        check_outcome(commit, expw, "R2 array contents");

        // R3: eleven bytes from slot 6 wrap and overwrite
        clear_obs(); m_start(8'h96);
        for (int i = 0; i < 11; i++) m_byte(8'(8'h30 + i));
        m_close(0, 1, commit, expw); settle();
        check(expw == PB, "R3 full page written once", wr_cnt, PB);
        check_outcome(commit, expw, "R3 wrapped contents");

        // R4: partial byte at chip select rise
        clear_obs(); m_start(8'h10);
        m_byte(8'h55); m_byte(8'h66);
        m_close(1, 1, commit, expw); settle();
        check_outcome(commit, expw, "R4 no program on partial byte");
        check(busy_rises == 0, "R4 no busy on partial byte", busy_rises, 0);

        // R4: no byte received
        clear_obs(); m_start(8'h20);
        m_close(0, 1, commit, expw); settle();
        check(busy_rises == 0, "R4 no busy without data", busy_rises, 0);

        // R5: not permitted, then an empty-permitted close must not revive old bytes
        clear_obs(); m_start(8'h28);
        m_byte(8'h77); m_byte(8'h88);
        m_close(0, 0, commit, expw); settle();
        check_outcome(commit, expw, "R5 denied write");
        clear_obs(); m_start(8'h28);
        m_close(0, 1, commit, expw); settle();
        check(busy_rises == 0 && wr_cnt == 0, "R5 stale bytes discarded", wr_cnt, 0);

        // R9: traffic during busy is ignored
        clear_obs(); m_start(8'h60);
        m_byte(8'hC1);
        m_close(0, 1, commit, expw);
        drive_start(8'h70); drive_byte(8'hEE); drive_byte(8'hEF); drive_close(0, 1);
        settle();
        check(busy_rises == 1, "R9 single program cycle", busy_rises, 1);
        check_outcome(commit, expw, "R9 busy traffic ignored");

        // R10: restart discards earlier bytes
        clear_obs(); m_start(8'hA0);
        m_byte(8'h11); m_byte(8'h12); m_byte(8'h13);
        m_start(8'hB3);
        m_byte(8'h21); m_byte(8'h22);
        m_close(0, 1, commit, expw); settle();
        check(wr_cnt == 2, "R10 only restarted bytes", wr_cnt, 2);
        check_outcome(commit, expw, "R10 restart contents");

        // R11: chip select rise with nothing open
        clear_obs(); drive_close(0, 1); settle();
        check(busy_rises == 0 && wr_cnt == 0, "R11 idle close ignored", busy_rises, 0);

        // random transactions
        for (int t = 0; t < 40; t++) begin
            clear_obs();
            a = 8'($urandom);
            n = int'($urandom_range(1, 13));
            m_start(a);
            for (int i = 0; i < n; i++) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                m_byte(8'($urandom));
            end
            m_close(($urandom_range(0, 7) == 0), ($urandom_range(0, 7) != 0), commit, expw);
            settle();
            check_outcome(commit, expw, "R2 R3 random contents");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule